// File: doc/BRIEF.md
# Smart-Card Character Receiver with Parity-Error Signalling

This block receives asynchronous characters from a smart-card style half-duplex line. Each character is framed by a low start bit, carries eight data bits sent least significant bit first, then an even-parity bit and a stop bit. The block times the bits with a programmable clocks-per-bit divider and samples each bit once, at its centre. A start bit is accepted only if the line is still low half a bit after the falling edge. A completed character goes into a one-entry receive buffer. The buffer exposes the byte, a parity-error flag, a ready flag and a sticky overrun flag.

When error signalling is enabled and a character fails its parity check, the block pulls its transmit line low. It does this from the stop-bit time of that character, so the card sees the error and can repeat the character. The line stays low until the host reads the buffer. That read clears the parity-error flag and releases the line high in the same clock edge.

The host interface has four parts: a read strobe, an enable for the error signal, the divider value and the buffer outputs.

Top module: `scard_rx`

## Requirements
- R1: A frame is one low start bit, then eight data bits with the first received bit stored in bit 0 of `rd_data`, then a parity bit, then a stop bit. There is no level inversion.
- R2: Parity is even: over the eight data bits plus the parity bit, the number of ones must be even. `rd_parity_err` is 1 when that count is odd. It is set on the same clock edge as `rd_ready`, and it is never 1 while `rd_ready` is 0.
- R3: When `err_sig_en` is 1 and a character completes with a parity error, `tx_line` goes low at the stop-bit centre of that character. It stays low until a read.
- R4: A `rd_strobe` pulse clears `rd_parity_err` and `rd_ready`, and it sets `tx_line` high on the same clock edge.
- R5: While `err_sig_en` is 0, `tx_line` is high from the next clock edge on. This includes dropping the enable while the line is held low.
- R6: `rd_ready` is set when a character completes and is cleared by a read.
- R7: A low on `rx_line` that is gone by the half-bit point is not taken as a start bit. No character results.
- R8: If a character completes while `rd_ready` is 1 and no read occurs in that cycle, the buffer takes the new byte and `rd_overrun` is set. `rd_overrun` stays set until a read clears it.
- R9: If a character completes in the same cycle as a read, the read consumes the old character and the new one is kept. `rd_ready` stays 1, `rd_overrun` stays 0 and `rd_data` holds the new byte.
- R10: Bit timing follows `clks_per_bit` (minimum 4). The start check happens `clks_per_bit/2` clocks after the falling edge, and each later bit is sampled `clks_per_bit` clocks after the previous sample.
- R11: After reset, `tx_line` is 1 and `rd_ready`, `rd_parity_err` and `rd_overrun` are 0.
- R12: A character with correct parity never drives `tx_line` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial receive line from the card (idle high) |
| clks_per_bit | input | 16 | Clock cycles per bit period |
| err_sig_en | input | 1 | Enables the parity-error low on `tx_line` |
| rd_strobe | input | 1 | One-cycle buffer read pulse |
| rd_data | output | 8 | Received byte |
| rd_ready | output | 1 | A character is waiting in the buffer |
| rd_parity_err | output | 1 | The buffered character failed even parity |
| rd_overrun | output | 1 | An unread character was overwritten |
| tx_line | output | 1 | Error signal to the card; low means parity error |

## Verification
Two things can land on the same clock edge: a character completing into the buffer and the host reading the buffer. The bench fixes that overlap by counting cycles from the start bit to the edge where the buffer loads: two synchronizer stages, the half-bit start check, ten bit periods and one registered hand-off. It raises the read strobe exactly then, while the previous character is still unread. The result must show the new byte with the ready flag still set and no overrun. Taking the read as the winner would lose the byte, and taking the completion as the winner would flag a false overrun, so either mistake shows up at the outputs.

// File: rtl/scard_rx_pkg.sv
package scard_rx_pkg;

  // Receive sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_CPB_W  = 16;
  localparam int unsigned DEF_SYNC   = 2;

endpackage

// File: rtl/scard_rx_sync.sv
module scard_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  // Each stage copies the previous one; stage 0 takes the raw input.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= RST_VAL;
        else     chain_q[g] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= RST_VAL;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/scard_rx_frame.sv
module scard_rx_frame
  import scard_rx_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CPB_W  = DEF_CPB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_s,
  input  logic [CPB_W-1:0]  cpb_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o
);

  localparam int unsigned       IDX_W    = $clog2(DATA_W + 1);
  localparam logic [CPB_W-1:0]  ONE      = CPB_W'(1);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0]  FULL_IDX = IDX_W'(DATA_W);

  rx_state_e         st_q;
  logic [CPB_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic              done_q;
  logic [DATA_W-1:0] data_q;
  logic              perr_q;

  logic [CPB_W-1:0]  half_m1;
  logic [CPB_W-1:0]  full_m1;
  logic              at_half;
  logic              at_full;

  assign half_m1 = (cpb_i >> 1) - ONE;
  assign full_m1 = cpb_i - ONE;
  assign at_half = (cnt_q == half_m1);
  assign at_full = (cnt_q == full_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          idx_q <= '0;
          if (!rx_s) st_q <= ST_START;
        end
        ST_START: begin
          if (at_half) begin
            cnt_q <= '0;
            par_q <= 1'b0;
            st_q  <= rx_s ? ST_IDLE : ST_DATA;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        ST_DATA: begin
          if (at_full) begin
            cnt_q   <= '0;
            shreg_q <= {rx_s, shreg_q[DATA_W-1:1]};
            par_q   <= par_q ^ rx_s;
            idx_q   <= idx_q + IDX_W'(1);
            if (idx_q == LAST_IDX) st_q <= ST_PAR;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        ST_PAR: begin
          if (at_full) begin
            cnt_q <= '0;
            par_q <= par_q ^ rx_s;
            st_q  <= ST_STOP;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        ST_STOP: begin
          if (at_full) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
            data_q <= shreg_q;
            perr_q <= par_q;
            st_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign perr_o = perr_q;

  // R1: the data bit index never runs past the character width
  assert_idx_bound_R1: assert property (@(posedge clk) disable iff (rst)
    idx_q <= FULL_IDX);

  // R1: while shifting data bits, the index stays below the width
  assert_data_idx_R1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA) |-> (idx_q <= LAST_IDX));

  // R6: completion is a single-cycle event
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R10: a character completes only from the stop state at the bit end
  assert_done_from_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STOP && at_full) |=> done_q);

endmodule

// File: rtl/scard_rx_hold.sv
module scard_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              rd_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_ready,
  output logic              buf_perr,
  output logic              buf_ovr,
  output logic              tx_o
);

  logic [DATA_W-1:0] data_q;
  logic              ready_q;
  logic              perr_q;
  logic              ovr_q;
  logic              tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      tx_q    <= 1'b1;
    end else if (done_i) begin
      // A read in the same cycle consumes the old character first.
      data_q  <= data_i;
      ready_q <= 1'b1;
      perr_q  <= perr_i;
      ovr_q   <= !rd_i && (ovr_q || ready_q);
      tx_q    <= !(perr_i && en_i);
    end else if (rd_i) begin
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      tx_q    <= 1'b1;
    end else if (!en_i) begin
      tx_q    <= 1'b1;
    end
  end

  assign buf_data  = data_q;
  assign buf_ready = ready_q;
  assign buf_perr  = perr_q;
  assign buf_ovr   = ovr_q;
  assign tx_o      = tx_q;

  // R2: an error flag only exists alongside a buffered character
  assert_perr_needs_ready_R2: assert property (@(posedge clk) disable iff (rst)
    perr_q |-> ready_q);

  // R3: the line is only low while a parity error is on record
  assert_low_has_perr_R3: assert property (@(posedge clk) disable iff (rst)
    !tx_q |-> perr_q);

  // R4: a read with no completion releases the line and clears flags
  assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !done_i) |=> (tx_q && !perr_q && !ready_q));

  // R5: with signalling disabled the line goes high on the next edge
  assert_disabled_high_R5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> tx_q);

  // R8: completion onto an unread buffer without a read flags overrun
  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
    (done_i && ready_q && !rd_i) |=> (ovr_q && ready_q));

  // R9: completion together with a read keeps the new char, no overrun
  assert_coincide_R9: assert property (@(posedge clk) disable iff (rst)
    (done_i && rd_i) |=> (ready_q && !ovr_q));

endmodule

// File: rtl/scard_rx.sv
module scard_rx
  import scard_rx_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CPB_W  = DEF_CPB_W,
  parameter int unsigned SYNC_N = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic [CPB_W-1:0]  clks_per_bit,
  input  logic              err_sig_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              rd_parity_err,
  output logic              rd_overrun,
  output logic              tx_line
);

  logic              rx_s;
  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  logic              fr_perr;

  scard_rx_sync #(
    .STAGES  (SYNC_N),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (rx_line),
    .d_out (rx_s)
  );

  scard_rx_frame #(
    .DATA_W (DATA_W),
    .CPB_W  (CPB_W)
  ) u_frame (
    .clk    (clk),
    .rst    (rst),
    .rx_s   (rx_s),
    .cpb_i  (clks_per_bit),
    .done_o (fr_done),
    .data_o (fr_data),
    .perr_o (fr_perr)
  );

  scard_rx_hold #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk       (clk),
    .rst       (rst),
    .done_i    (fr_done),
    .data_i    (fr_data),
    .perr_i    (fr_perr),
    .rd_i      (rd_strobe),
    .en_i      (err_sig_en),
    .buf_data  (rd_data),
    .buf_ready (rd_ready),
    .buf_perr  (rd_parity_err),
    .buf_ovr   (rd_overrun),
    .tx_o      (tx_line)
  );

  // R12: a character with good parity never pulls the line low
  assert_good_stays_high_R12: assert property (@(posedge clk) disable iff (rst)
    (fr_done && !fr_perr) |=> tx_line);

endmodule

// File: tb/scard_rx_bench.sv
module scard_rx_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_line;
  logic [15:0] clks_per_bit;
  logic        err_sig_en;
  logic        rd_strobe;
  logic [7:0]  rd_data;
  logic        rd_ready;
  logic        rd_parity_err;
  logic        rd_overrun;
  logic        tx_line;

  int checks   = 0;
  int failures = 0;
  bit saw_low  = 1'b0;

  always #5 clk = ~clk;

  scard_rx u_scard_rx (
    .clk           (clk),
    .rst           (rst),
    .rx_line       (rx_line),
    .clks_per_bit  (clks_per_bit),
    .err_sig_en    (err_sig_en),
    .rd_strobe     (rd_strobe),
    .rd_data       (rd_data),
    .rd_ready      (rd_ready),
    .rd_parity_err (rd_parity_err),
    .rd_overrun    (rd_overrun),
    .tx_line       (tx_line)
  );

  always @(negedge clk) if (!tx_line) saw_low = 1'b1;

  // Vector fields: {enable, bad parity, byte}
  localparam logic [9:0] VEC [6] = '{
    {1'b1, 1'b0, 8'hA5},
    {1'b1, 1'b1, 8'h3C},
    {1'b0, 1'b1, 8'h81},
    {1'b1, 1'b0, 8'h00},
    {1'b1, 1'b1, 8'hFF},
    {1'b0, 1'b0, 8'h6E}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives a whole frame starting at a negedge; ends 11 bit periods later.
  task automatic send_frame(input logic [7:0] b, input logic bad);
    logic [10:0] bits;
    bits = {1'b1, (^b) ^ bad, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rx_line = bits[i];
      repeat (int'(clks_per_bit)) @(negedge clk);
    end
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; rx_line = 1'b1; clks_per_bit = 16'd8;
    err_sig_en = 1'b1; rd_strobe = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11: reset state
    chk("R11 tx_line", tx_line, 1);
    chk("R11 ready", rd_ready, 0);
    chk("R11 perr", rd_parity_err, 0);
    chk("R11 overrun", rd_overrun, 0);

    // Vector table walk (R1, R2, R3, R4, R5, R6, R12)
    for (int v = 0; v < 6; v++) begin
      err_sig_en = VEC[v][9];
      saw_low = 1'b0;
      send_frame(VEC[v][7:0], VEC[v][8]);
      chk("R1 data", rd_data, VEC[v][7:0]);
      chk("R2 perr", rd_parity_err, VEC[v][8]);
      chk("R6 ready", rd_ready, 1);
      chk("R3 tx level", tx_line, !(VEC[v][9] && VEC[v][8]));
      if (!(VEC[v][9] && VEC[v][8])) chk("R12/R5 no low seen", saw_low, 0);
      repeat (20) @(negedge clk);
      chk("R3 tx held", tx_line, !(VEC[v][9] && VEC[v][8]));
      do_read();
      chk("R4 tx released", tx_line, 1);
      chk("R4 perr cleared", rd_parity_err, 0);
      chk("R6 ready cleared", rd_ready, 0);
    end
    err_sig_en = 1'b1;

    // R7: short glitch is not a start bit
    rx_line = 1'b0;
    repeat (2) @(negedge clk);
    rx_line = 1'b1;
    repeat (100) @(negedge clk);
    chk("R7 no char", rd_ready, 0);
    send_frame(8'h5A, 1'b0);
    chk("R7 resync data", rd_data, 8'h5A);
    do_read();

    // R10: different divider
    clks_per_bit = 16'd12;
    send_frame(8'hC3, 1'b0);
    chk("R10 data cpb12", rd_data, 8'hC3);
    chk("R10 ready cpb12", rd_ready, 1);
    do_read();
    send_frame(8'h17, 1'b1);
    chk("R10 perr cpb12", rd_parity_err, 1);
    do_read();
    clks_per_bit = 16'd8;

    // R8: overrun
    send_frame(8'h11, 1'b0);
    chk("R8 no overrun yet", rd_overrun, 0);
    send_frame(8'h22, 1'b0);
    chk("R8 overrun set", rd_overrun, 1);
    chk("R8 newest data", rd_data, 8'h22);
    repeat (10) @(negedge clk);
    chk("R8 sticky", rd_overrun, 1);
    do_read();
    chk("R8 cleared", rd_overrun, 0);

    // R9: read lands on the completion edge (start + 87 cycles at cpb 8)
    send_frame(8'h44, 1'b0);
    fork
      send_frame(8'h99, 1'b0);
      begin
        repeat (87) @(negedge clk);
        do_read();
      end
    join
    chk("R9 ready kept", rd_ready, 1);
    chk("R9 no overrun", rd_overrun, 0);
    chk("R9 new data", rd_data, 8'h99);
    do_read();

    // R5: drop the enable while the line is held low
    send_frame(8'h0F, 1'b1);
    chk("R3 low on error", tx_line, 0);
    err_sig_en = 1'b0;
    @(negedge clk);
    chk("R5 released by disable", tx_line, 1);
    chk("R5 perr still flagged", rd_parity_err, 1);
    err_sig_en = 1'b1;
    do_read();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule